// File: doc/BRIEF.md
# Overcurrent Protection Gate Sequencer

This block decides, each clock cycle, which level a power-switch gate driver should apply. The inputs are a PWM on command, a digitized overcurrent comparator, a cold-temperature flag and an overtemperature flag. The output is one of four levels: off, full supply, a reduced two-level plateau, or soft shutdown. There is also a latched fault output.

After every turn-on, overcurrent detection is masked for a programmable blanking window. Once blanking has ended, a sustained overcurrent first passes through a fixed detection interval. During that interval the gate can optionally be held at the plateau. If the overcurrent is still present when the interval ends, a fault is registered and the gate is turned off through a timed soft shutdown.

A 24-bit configuration word selects the mode bits, and they interact during an overcurrent event. One bit drives the plateau while blanking is active. A second keeps full drive during the detection interval. A third skips the detection interval and goes straight to soft shutdown. The fault stays latched until a clear pulse arrives while the PWM input is low.

Top module: `ocp_gate_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `gate_lvl_o` is 0 (off) and `fault_o` is 0. Level encoding: 0 off, 1 full, 2 plateau, 3 soft shutdown.
- R2: The gate leaves off for the blanking window one cycle after an on command is sampled with no fault latched. While the gate is at full or plateau, a low PWM input gives off on the next cycle.
- R3: The blanking window lasts 16×(N+1) cycles, where N is `cfg_i[10:7]`. With `cfg_i[11]`=0, overcurrent inside the window has no effect on the level.
- R4: With `cfg_i[11]`=1, the gate shows plateau (2) in every blanking cycle where `oc_i` is high. It shows the normal drive level in the other blanking cycles.
- R5: An overcurrent seen after blanking starts a 64-cycle detection interval on the next cycle. During that interval the level is plateau if `cfg_i[13]`=0 and the normal drive level if `cfg_i[13]`=1.
- R6: An overcurrent that is still present at the end of the detection interval sets `fault_o` and gives soft shutdown (3) for 8 cycles, then off.
- R7: If the overcurrent drops during the detection interval, the gate returns to the normal drive level on the next cycle and no fault is set.
- R8: With `cfg_i[14]`=1, an overcurrent after blanking gives soft shutdown and a fault on the next cycle, with no detection interval. Blanking still applies.
- R9: The normal drive level is plateau when `cold_i`=1 and `cfg_i[12]`=0. It is full otherwise.
- R10: `ot_i` sets the fault when `cfg_i[16]`=0, and a driven gate then goes to soft shutdown. With `cfg_i[16]`=1, `ot_i` has no effect.
- R11: A latched fault blocks on commands. It is cleared only by `flt_clr_i` sampled while `pwm_on_i` is low. A clear sampled while the PWM input is high leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_on_i | input | 1 | Gate on command |
| oc_i | input | 1 | Digitized overcurrent comparator |
| cold_i | input | 1 | Sensed temperature below the low threshold |
| ot_i | input | 1 | Overtemperature detected |
| flt_clr_i | input | 1 | Fault clear request |
| cfg_i | input | 24 | Configuration trim word |
| gate_lvl_o | output | 2 | Selected gate level |
| fault_o | output | 1 | Latched fault |

## Verification
Every input is driven on the falling edge. The step count t starts at 1 on the first rising edge that samples the on command. For blanking length B, the gate sits in blanking for t=1..B and in plain drive at t=B+1. Detection covers t=B+2..B+65 and soft shutdown covers t=B+66..B+73. With immediate shutdown selected, soft shutdown instead starts at t=B+2. The plateau shown during blanking comes from `oc_i` within the same cycle. The bench samples 2 ns after each rising edge, compares every cycle of each sequence with these arithmetic predictions, and repeats the sweep over all eight settings of the three overcurrent mode bits at two blanking lengths.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    LVL_OFF  = 2'd0,
    LVL_FULL = 2'd1,
    LVL_PLAT = 2'd2,
    LVL_SSD  = 2'd3
  } lvl_e;

  typedef enum logic [2:0] {
    ST_OFF, ST_BLANK, ST_ON, ST_DET, ST_SSD
  } state_e;

  typedef struct packed {
    logic       ot_dis;
    logic       tmr_dis;
    logic       two_dis;
    logic       lowt_dis;
    logic       blank_opt;
    logic [3:0] blank;
  } cfg_t;
endpackage

// File: rtl/ocp_cnt.sv
module ocp_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ocp_fault.sv
module ocp_fault (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic pwm_on_i,
  output logic fault_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 fault_o <= 1'b0;
    else if (set_i)              fault_o <= 1'b1;
    else if (clr_i && !pwm_on_i) fault_o <= 1'b0;
  end
endmodule

// File: rtl/ocp_lvl_sel.sv
module ocp_lvl_sel
  import ocp_pkg::*;
(
  input  state_e state_i,
  input  logic   cold_i,
  input  logic   oc_i,
  input  cfg_t   cfg_i,
  output lvl_e   lvl_o
);
  lvl_e norm_lvl;

  assign norm_lvl = (cold_i && !cfg_i.lowt_dis) ? LVL_PLAT : LVL_FULL;

  always_comb begin
    unique case (state_i)
      ST_BLANK: lvl_o = (cfg_i.blank_opt && oc_i) ? LVL_PLAT : norm_lvl;
      ST_ON:    lvl_o = norm_lvl;
      ST_DET:   lvl_o = cfg_i.two_dis ? norm_lvl : LVL_PLAT;
      ST_SSD:   lvl_o = LVL_SSD;
      default:  lvl_o = LVL_OFF;
    endcase
  end
endmodule

// File: rtl/ocp_gate_seq.sv
module ocp_gate_seq
  import ocp_pkg::*;
#(
  parameter int BLANK_UNIT = 16,
  parameter int DET_CYC    = 64,
  parameter int SSD_CYC    = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pwm_on_i,
  input  logic        oc_i,
  input  logic        cold_i,
  input  logic        ot_i,
  input  logic        flt_clr_i,
  input  logic [23:0] cfg_i,
  output logic [1:0]  gate_lvl_o,
  output logic        fault_o
);
  localparam int BLANK_MAX = BLANK_UNIT * 16;
  localparam int CNT_MAX   = (BLANK_MAX > DET_CYC) ?
                             ((BLANK_MAX > SSD_CYC) ? BLANK_MAX : SSD_CYC) :
                             ((DET_CYC > SSD_CYC) ? DET_CYC : SSD_CYC);
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  cfg_t   cfg;
  state_e state_q, state_d;
  logic   cnt_zero, cnt_load, ot_trip, go_ssd;
  logic   [CNT_W-1:0] cnt_val, blank_ld;
  lvl_e   lvl;
  logic   unused_cfg;

  assign cfg.blank     = cfg_i[10:7];
  assign cfg.blank_opt = cfg_i[11];
  assign cfg.lowt_dis  = cfg_i[12];
  assign cfg.two_dis   = cfg_i[13];
  assign cfg.tmr_dis   = cfg_i[14];
  assign cfg.ot_dis    = cfg_i[16];
  assign unused_cfg    = ^{cfg_i[23:17], cfg_i[15], cfg_i[6:0]};

  assign ot_trip  = ot_i && !cfg.ot_dis;
  assign blank_ld = CNT_W'(BLANK_UNIT) * (CNT_W'(cfg.blank) + 1'b1) - 1'b1;

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    go_ssd   = 1'b0;
    unique case (state_q)
      ST_OFF:
        if (pwm_on_i && !fault_o && !ot_trip) begin
          state_d  = ST_BLANK;
          cnt_load = 1'b1;
          cnt_val  = blank_ld;
        end
      ST_BLANK:
        if (!pwm_on_i)     state_d = ST_OFF;
        else if (ot_trip)  go_ssd  = 1'b1;
        else if (cnt_zero) state_d = ST_ON;
      ST_ON:
        if (!pwm_on_i)     state_d = ST_OFF;
        else if (ot_trip || (oc_i && cfg.tmr_dis)) go_ssd = 1'b1;
        else if (oc_i) begin
          state_d  = ST_DET;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(DET_CYC - 1);
        end
      ST_DET:
        if (!pwm_on_i)     state_d = ST_OFF;
        else if (ot_trip)  go_ssd  = 1'b1;
        else if (!oc_i)    state_d = ST_ON;
        else if (cnt_zero) go_ssd  = 1'b1;
      ST_SSD:
        if (cnt_zero)      state_d = ST_OFF;
      default:             state_d = ST_OFF;
    endcase
    if (go_ssd) begin
      state_d  = ST_SSD;
      cnt_load = 1'b1;
      cnt_val  = CNT_W'(SSD_CYC - 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  ocp_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .val_i  (cnt_val),
    .zero_o (cnt_zero)
  );

  ocp_fault u_fault (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (go_ssd || ot_trip),
    .clr_i    (flt_clr_i),
    .pwm_on_i (pwm_on_i),
    .fault_o  (fault_o)
  );

  ocp_lvl_sel u_lvl (
    .state_i (state_q),
    .cold_i  (cold_i),
    .oc_i    (oc_i),
    .cfg_i   (cfg),
    .lvl_o   (lvl)
  );

  assign gate_lvl_o = lvl;
endmodule

// File: rtl/ocp_gate_seq_chk.sv
module ocp_gate_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwm_on_i,
  input logic       flt_clr_i,
  input logic [1:0] gate_lvl_o,
  input logic       fault_o
);
  // R6
  ssd_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_lvl_o == 2'd3 |-> fault_o);

  // R6
  ssd_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_lvl_o == 2'd3 |=> (gate_lvl_o == 2'd3 || gate_lvl_o == 2'd0));

  // R11
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && !(flt_clr_i && !pwm_on_i) |=> fault_o);

  // R11
  fault_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && gate_lvl_o == 2'd0 |=> gate_lvl_o == 2'd0);

  // R2
  pwm_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_on_i && (gate_lvl_o == 2'd1 || gate_lvl_o == 2'd2) |=> gate_lvl_o == 2'd0);
endmodule

bind ocp_gate_seq ocp_gate_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwm_on_i   (pwm_on_i),
  .flt_clr_i  (flt_clr_i),
  .gate_lvl_o (gate_lvl_o),
  .fault_o    (fault_o)
);

// File: tb/ocp_gate_seq_bench.sv
`timescale 1ns/1ps
module ocp_gate_seq_bench;
  localparam int BU = 16;
  localparam int DC = 64;
  localparam int SC = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwm_on, oc, cold, ot, clr;
  logic [23:0] cfg;
  logic [1:0]  lvl;
  logic        flt;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ocp_gate_seq #(.BLANK_UNIT(BU), .DET_CYC(DC), .SSD_CYC(SC)) u_ocp_gate_seq (
    .clk_i(clk), .rst_ni(rst_ni), .pwm_on_i(pwm_on), .oc_i(oc), .cold_i(cold),
    .ot_i(ot), .flt_clr_i(clr), .cfg_i(cfg), .gate_lvl_o(lvl), .fault_o(flt)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic drv(input logic p, input logic o);
    @(negedge clk); pwm_on = p; oc = o;
  endtask

  task automatic clear_fault();
    @(negedge clk); pwm_on = 0; oc = 0; ot = 0; clr = 1;
    step();
    @(negedge clk); clr = 0;
    chk("R11 clear", flt, 0);
    chk("R11 clear lvl", lvl, 0);
  endtask

  function automatic logic [23:0] mk(int f, bit bo, bit lt, bit td, bit tm, bit od);
    logic [23:0] c = '0;
    c[10:7] = 4'(f); c[11] = bo; c[12] = lt; c[13] = td; c[14] = tm; c[16] = od;
    return c;
  endfunction

  // Overcurrent held high from turn-on; full sequence compared per cycle.
  task automatic run_oc(input int f, input bit bo, input bit td, input bit tm);
    int b, el, ef;
    b = BU * (f + 1);
    @(negedge clk); cfg = mk(f, bo, 0, td, tm, 0);
    drv(1, 1);
    for (int t = 1; t <= b + DC + SC + 3; t++) begin
      step();
      ef = 0;
      if (t <= b)          el = bo ? 2 : 1;
      else if (t == b + 1) el = 1;
      else if (tm) begin
        el = (t <= b + 1 + SC) ? 3 : 0; ef = 1;
      end else if (t <= b + 1 + DC) el = td ? 1 : 2;
      else begin
        el = (t <= b + 1 + DC + SC) ? 3 : 0; ef = 1;
      end
      if (t <= b)                 chk("R3 R4 blank lvl", lvl, el);
      else if (tm)                chk("R8 immediate ssd", lvl, el);
      else if (t <= b + 1 + DC)   chk("R5 detect lvl", lvl, el);
      else                        chk("R6 ssd lvl", lvl, el);
      chk("R6 R8 fault", flt, ef);
    end
    chk("R11 blocked on", lvl, 0);
    clear_fault();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0 exp 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    pwm_on = 0; oc = 0; cold = 0; ot = 0; clr = 0; cfg = '0;
    #12;
    chk("R1 reset lvl", lvl, 0);
    chk("R1 reset fault", flt, 0);
    @(negedge clk); rst_ni = 1;
    step();
    chk("R1 post reset lvl", lvl, 0);
    chk("R1 post reset fault", flt, 0);

    // All 8 combinations of the three overcurrent mode bits, two blank lengths
    for (int f = 0; f < 3; f += 2)
      for (int m = 0; m < 8; m++)
        run_oc(f, m[0], m[1], m[2]);

    // R2 turn-on and turn-off, R3 oc masked (bit11=0), R7 oc drop in detect
    @(negedge clk); cfg = mk(0, 0, 0, 0, 0, 0);
    drv(1, 0);
    step(); chk("R2 turn on", lvl, 1);
    for (int t = 2; t <= BU + 1; t++) step();
    drv(1, 1);
    step(); chk("R5 detect start", lvl, 2);
    for (int t = 0; t < 10; t++) step();
    chk("R5 detect hold", lvl, 2);
    drv(1, 0);
    step(); chk("R7 back to full", lvl, 1);
    chk("R7 no fault", flt, 0);
    drv(0, 0);
    step(); chk("R2 turn off", lvl, 0);

    // R9 cold with low-temp op enabled / disabled
    @(negedge clk); cold = 1; cfg = mk(0, 0, 0, 0, 0, 0);
    drv(1, 0);
    step(); chk("R9 cold plateau", lvl, 2);
    drv(0, 0); step();
    @(negedge clk); cfg = mk(0, 0, 1, 0, 0, 0);
    drv(1, 0);
    step(); chk("R9 cold disabled full", lvl, 1);
    drv(0, 0); step();
    @(negedge clk); cold = 0;

    // R10 overtemperature disabled then enabled
    @(negedge clk); cfg = mk(0, 0, 0, 0, 0, 1);
    drv(1, 0);
    for (int t = 0; t < BU + 3; t++) step();
    @(negedge clk); ot = 1;
    step(); chk("R10 ot ignored lvl", lvl, 1);
    chk("R10 ot ignored fault", flt, 0);
    @(negedge clk); cfg = mk(0, 0, 0, 0, 0, 0);
    step(); chk("R10 ot ssd", lvl, 3);
    chk("R10 ot fault", flt, 1);
    @(negedge clk); ot = 0; clr = 1;
    step(); chk("R11 clear ignored while on", flt, 1);
    @(negedge clk); clr = 0;
    for (int t = 0; t < SC + 2; t++) step();
    chk("R11 on blocked", lvl, 0);
    clear_fault();
    drv(1, 0);
    step(); chk("R11 on after clear", lvl, 1);
    drv(0, 0); step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule